// File: doc/BRIEF.md
# Bit-Oriented Codeword Message Receiver

This block watches a serial data-link bit stream that has already been pulled out of its channel. Each bit arrives with a one-cycle bit-enable strobe. The block looks for repeating 16-bit bit-oriented messages. Each message is a run of eight ones, then a zero, then six codeword bits, then a closing zero. Once the block has found the ones flag, it stays locked to the message boundary. It expects every following message to start on the very next strobed bit.

Each complete message yields a 6-bit codeword. A qualification stage counts how many identical messages arrive in an unbroken run. The stage can also apply an integration filter, which asks for two identical back-to-back messages before a first codeword may be accepted. When a run qualifies, the codeword goes into a result register that carries a valid flag and a lost flag, and a one-cycle interrupt pulse is raised. A processor reads the result with a read strobe. A live status output shows whether well-formed messages are currently arriving.

Top module: `bop_msg_rx`

## Requirements
- R1: Message bits are taken in arrival order: eight ones, a zero, codeword bit 0 through bit 5 (least significant first), then a zero. With `len_sel`=2'b00 and integration off, the first complete message loads its codeword into `cw_out`.
- R2: Each load sets `cw_valid`. A `rd_strobe` pulse with no load in the same cycle clears both `cw_valid` and `cw_lost` on the next cycle.
- R3: A load that lands while `cw_valid` is still set, with no read in that cycle, sets `cw_lost`.
- R4: `len_sel` sets how many identical messages in a row are needed before a load: 2'b00 needs 1, 2'b01 needs 10, and 2'b10 or 2'b11 needs 25. The load happens on exactly that message.
- R5: A codeword that differs from the one being counted restarts the run count at 1, with the new codeword as the one being counted.
- R6: With `integ_en` high and `len_sel`=2'b00, a codeword loads only on the second of two identical messages in a row. A single message followed by a different one loads nothing.
- R7: A framing violation while locked ends the run: a zero where a flag one is expected, a one in either zero slot, or any stray bit between messages. The count then restarts from zero.
- R8: A qualified codeword that keeps repeating without a break loads only once.
- R9: `active` rises after the first complete message. It falls after a framing violation or when `enable` is low.
- R10: While `enable` is low, nothing is received and the detector, the count and `active` are held reset. `cw_out`, `cw_valid` and `cw_lost` keep their values.
- R11: `cw_irq` is a single-cycle pulse, given once per load, in the cycle in which the new value appears on `cw_out`.
- R12: After reset, `cw_out` is 0 and `cw_valid`, `cw_lost`, `cw_irq` and `active` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Reception enable; low holds the detector reset |
| len_sel | input | 2 | Run length select: 00 = 1, 01 = 10, 10/11 = 25 |
| integ_en | input | 1 | Integration filter enable |
| bit_en | input | 1 | Strobe marking a valid bit on `bit_in` |
| bit_in | input | 1 | Serial data-link bit |
| rd_strobe | input | 1 | Processor read of the result register |
| cw_out | output | 6 | Last loaded codeword |
| cw_valid | output | 1 | Unread codeword present |
| cw_lost | output | 1 | An unread codeword was overwritten |
| cw_irq | output | 1 | One-cycle pulse on each load |
| active | output | 1 | Well-formed messages are currently being received |

## Verification
A wrong bit position or bit order inside the framer shows up on `cw_out` two cycles after the last bit of the first message. It shows either as a reversed codeword or as no load at all, with `active` staying low. A run counter that starts at the wrong value, or that is not cleared on a break, moves the `cw_irq` pulse by one whole message, which is 16 strobes, so the bench counts pulses after each message boundary. Flag-handling errors in the result register appear on `cw_valid` and `cw_lost` one cycle after the read or load that should have changed them.

// File: rtl/bop_pkg.sv
// Shared constants and types for the bit-oriented codeword message receiver.
// Assumes the message layout: flag ones, one zero, codeword, one zero.
package bop_pkg;
    localparam int BOP_CW_W      = 6;
    localparam int BOP_FLAG_ONES = 8;
    localparam int BOP_RUN_SHORT = 1;
    localparam int BOP_RUN_MID   = 10;
    localparam int BOP_RUN_LONG  = 25;

    // Encoding of the run-length select field
    typedef enum logic [1:0] {
        RUN_SHORT  = 2'b00,
        RUN_MID    = 2'b01,
        RUN_LONG_A = 2'b10,
        RUN_LONG_B = 2'b11
    } run_sel_e;
endpackage

// File: rtl/bop_msg_framer.sv
// Message framer: hunts for the ones flag, then tracks the bit position
// inside each message and pulls out the codeword least significant bit first.
// Assumes bits count only on bit_en; idle cycles without a strobe are not gaps.
// Emits a one-cycle msg_done with the codeword, or frame_err on any violation
// while locked. Holds everything reset while enable is low.
module bop_msg_framer #(
    parameter int CW_W      = 6,
    parameter int FLAG_ONES = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            bit_en,
    input  logic            bit_in,
    output logic            msg_done,
    output logic [CW_W-1:0] msg_cw,
    output logic            frame_err
);
    localparam int MSG_LEN = FLAG_ONES + CW_W + 2;
    localparam int POS_W   = $clog2(MSG_LEN);
    localparam int ONE_W   = $clog2(FLAG_ONES + 1);
    localparam logic [POS_W-1:0] P_START = POS_W'(FLAG_ONES);
    localparam logic [POS_W-1:0] P_CW0   = POS_W'(FLAG_ONES + 1);
    localparam logic [POS_W-1:0] P_END   = POS_W'(MSG_LEN - 1);
    localparam logic [ONE_W-1:0] ONES_FULL = ONE_W'(FLAG_ONES);

    logic             locked;
    logic [POS_W-1:0] pos;
    logic [ONE_W-1:0] ones;
    logic [CW_W-1:0]  shift_q;
    logic             bad_bit;

    // Classify the current strobed bit as a framing violation while locked
    always_comb begin
        bad_bit = 1'b0;
        if (locked) begin
            if (pos < P_START)      bad_bit = !bit_in;
            else if (pos == P_START) bad_bit = bit_in;
            else if (pos == P_END)   bad_bit = bit_in;
        end
    end

    // Hunt and track state machine with codeword shift register
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            locked    <= 1'b0;
            pos       <= '0;
            ones      <= '0;
            shift_q   <= '0;
            msg_done  <= 1'b0;
            msg_cw    <= '0;
            frame_err <= 1'b0;
        end else begin
            msg_done  <= 1'b0;
            frame_err <= 1'b0;
            if (bit_en) begin
                if (!locked) begin
                    if (bit_in) begin
                        if (ones != ONES_FULL) ones <= ones + 1'b1;
                    end else if (ones == ONES_FULL) begin
                        locked <= 1'b1;
                        pos    <= P_CW0;
                        ones   <= '0;
                    end else begin
                        ones <= '0;
                    end
                end else if (bad_bit) begin
                    locked    <= 1'b0;
                    frame_err <= 1'b1;
                    pos       <= '0;
                    if (!bit_in)             ones <= '0;
                    else if (pos == P_START) ones <= ONES_FULL;
                    else                     ones <= ONE_W'(1);
                end else if (pos == P_END) begin
                    msg_done <= 1'b1;
                    msg_cw   <= shift_q;
                    pos      <= '0;
                end else begin
                    if (pos >= P_CW0) shift_q <= {bit_in, shift_q[CW_W-1:1]};
                    pos <= pos + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/bop_qual_filter.sv
// Qualification filter: counts identical consecutive messages, applies the
// selected run length and the optional integration rule, and asks for one load
// per qualified run. Assumes msg_done and frame_err never coincide.
// Drives the live active status.
module bop_qual_filter
    import bop_pkg::*;
#(
    parameter int CW_W      = 6,
    parameter int RUN_SHORT_N = 1,
    parameter int RUN_MID_N   = 10,
    parameter int RUN_LONG_N  = 25
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic [1:0]      len_sel,
    input  logic            integ_en,
    input  logic            msg_done,
    input  logic [CW_W-1:0] msg_cw,
    input  logic            frame_err,
    output logic            load,
    output logic [CW_W-1:0] load_cw,
    output logic            active
);
    localparam int CNT_W = $clog2(RUN_LONG_N + 1) + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CW_W-1:0]  cur_cw;
    logic [CNT_W-1:0] cnt;
    logic             loaded;
    logic [CNT_W-1:0] need;
    logic [CNT_W-1:0] nxt_cnt;
    logic             same;

    // Required run length from the select field and the integration rule
    always_comb begin
        unique case (run_sel_e'(len_sel))
            RUN_SHORT: need = CNT_W'(RUN_SHORT_N);
            RUN_MID:   need = CNT_W'(RUN_MID_N);
            default:   need = CNT_W'(RUN_LONG_N);
        endcase
        if (integ_en && need < CNT_W'(2)) need = CNT_W'(2);
    end

    // Next run count and load decision for the arriving message
    always_comb begin
        same    = active && (msg_cw == cur_cw);
        nxt_cnt = same ? ((cnt == CNT_MAX) ? cnt : cnt + 1'b1) : CNT_W'(1);
        load    = msg_done && !(same && loaded) && (nxt_cnt >= need);
        load_cw = msg_cw;
    end

    // Run state: codeword counted, count, once-per-run flag, active status
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || frame_err) begin
            cur_cw <= '0;
            cnt    <= '0;
            loaded <= 1'b0;
            active <= 1'b0;
        end else if (msg_done) begin
            cur_cw <= msg_cw;
            cnt    <= nxt_cnt;
            loaded <= (same && loaded) || load;
            active <= 1'b1;
        end
    end
endmodule

// File: rtl/bop_result_reg.sv
// Result register: holds the last loaded codeword with valid and lost flags
// and raises a one-cycle interrupt on each load. A load wins over a read in
// the same cycle; that read counts as having taken the older codeword.
module bop_result_reg #(
    parameter int CW_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [CW_W-1:0] load_cw,
    input  logic            rd_strobe,
    output logic [CW_W-1:0] cw_out,
    output logic            cw_valid,
    output logic            cw_lost,
    output logic            cw_irq
);
    // Load, overwrite and read handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cw_out   <= '0;
            cw_valid <= 1'b0;
            cw_lost  <= 1'b0;
            cw_irq   <= 1'b0;
        end else begin
            cw_irq <= load;
            if (load) begin
                cw_out   <= load_cw;
                cw_valid <= 1'b1;
                cw_lost  <= cw_valid && !rd_strobe;
            end else if (rd_strobe) begin
                cw_valid <= 1'b0;
                cw_lost  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/bop_msg_rx.sv
// Top of the bit-oriented codeword message receiver: framer, qualification
// filter and result register in series. Assumes the bit stream is already
// taken from its channel and comes with a bit strobe.
module bop_msg_rx
    import bop_pkg::*;
#(
    parameter int CW_W        = BOP_CW_W,
    parameter int FLAG_ONES   = BOP_FLAG_ONES,
    parameter int RUN_SHORT_N = BOP_RUN_SHORT,
    parameter int RUN_MID_N   = BOP_RUN_MID,
    parameter int RUN_LONG_N  = BOP_RUN_LONG
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic [1:0]      len_sel,
    input  logic            integ_en,
    input  logic            bit_en,
    input  logic            bit_in,
    input  logic            rd_strobe,
    output logic [CW_W-1:0] cw_out,
    output logic            cw_valid,
    output logic            cw_lost,
    output logic            cw_irq,
    output logic            active
);
    logic            msg_done;
    logic [CW_W-1:0] msg_cw;
    logic            frame_err;
    logic            load;
    logic [CW_W-1:0] load_cw;

    bop_msg_framer #(.CW_W(CW_W), .FLAG_ONES(FLAG_ONES)) u_framer (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .bit_en(bit_en), .bit_in(bit_in),
        .msg_done(msg_done), .msg_cw(msg_cw), .frame_err(frame_err)
    );

    bop_qual_filter #(
        .CW_W(CW_W), .RUN_SHORT_N(RUN_SHORT_N),
        .RUN_MID_N(RUN_MID_N), .RUN_LONG_N(RUN_LONG_N)
    ) u_filter (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .len_sel(len_sel), .integ_en(integ_en),
        .msg_done(msg_done), .msg_cw(msg_cw), .frame_err(frame_err),
        .load(load), .load_cw(load_cw), .active(active)
    );

    bop_result_reg #(.CW_W(CW_W)) u_result (
        .clk(clk), .rst_n(rst_n), .load(load), .load_cw(load_cw),
        .rd_strobe(rd_strobe), .cw_out(cw_out), .cw_valid(cw_valid),
        .cw_lost(cw_lost), .cw_irq(cw_irq)
    );
endmodule

// File: rtl/bop_msg_rx_chk.sv
// Port-level checker for the message receiver, bound into every instance.
module bop_msg_rx_chk #(
    parameter int CW_W = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            enable,
    input logic            rd_strobe,
    input logic [CW_W-1:0] cw_out,
    input logic            cw_valid,
    input logic            cw_lost,
    input logic            cw_irq,
    input logic            active
);
    // R2: a read with nothing new arriving empties the register
    a_r2_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && cw_valid) |=> (!cw_valid || cw_irq));

    // R2: valid only rises together with a load
    a_r2_valid_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cw_valid) |-> cw_irq);

    // R3: lost never stands without an unread codeword
    a_r3_lost_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        cw_lost |-> cw_valid);

    // R11: the interrupt marks a fresh valid codeword
    a_r11_irq_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
        cw_irq |-> cw_valid);

    // R11: the interrupt lasts one cycle
    a_r11_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        cw_irq |=> !cw_irq);

    // R10: the codeword output only moves on a load
    a_r10_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        !cw_irq |-> $stable(cw_out));

    // R9: disabling reception drops the live status
    a_r9_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !active);
endmodule

bind bop_msg_rx bop_msg_rx_chk #(.CW_W(CW_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .rd_strobe(rd_strobe),
    .cw_out(cw_out), .cw_valid(cw_valid), .cw_lost(cw_lost),
    .cw_irq(cw_irq), .active(active)
);

// File: tb/bop_msg_rx_bench.sv
// Directed bench for the message receiver: one task per scenario.
module bop_msg_rx_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [1:0] len_sel = 2'b00;
    logic       integ_en = 1'b0;
    logic       bit_en = 1'b0;
    logic       bit_in = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [5:0] cw_out;
    logic       cw_valid, cw_lost, cw_irq, active;

    int n_chk = 0;
    int n_err = 0;
    int irq_cnt = 0;
    bit irq_prev = 1'b0;
    bit irq_wide = 1'b0;

    always #2.5 clk = ~clk;

    bop_msg_rx u_bop_msg_rx (
        .clk(clk), .rst_n(rst_n), .enable(enable), .len_sel(len_sel),
        .integ_en(integ_en), .bit_en(bit_en), .bit_in(bit_in),
        .rd_strobe(rd_strobe), .cw_out(cw_out), .cw_valid(cw_valid),
        .cw_lost(cw_lost), .cw_irq(cw_irq), .active(active)
    );

    // Count interrupt pulses and catch any that last two cycles
    always @(negedge clk) begin
        if (rst_n) begin
            if (cw_irq) irq_cnt++;
            if (cw_irq && irq_prev) irq_wide = 1'b1;
            irq_prev = cw_irq;
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_en = 1'b1;
        bit_in = b;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        bit_en = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // One message: flag ones, zero, codeword LSB first, zero
    task automatic send_msg(input logic [5:0] cw);
        for (int i = 0; i < 8; i++) send_bit(1'b1);
        send_bit(1'b0);
        for (int i = 0; i < 6; i++) send_bit(cw[i]);
        send_bit(1'b0);
    endtask

    task automatic send_n(input logic [5:0] cw, input int n);
        for (int i = 0; i < n; i++) send_msg(cw);
        idle(4);
    endtask

    task automatic break_stream();
        for (int i = 0; i < 3; i++) send_bit(1'b0);
        idle(4);
    endtask

    task automatic rd_reg();
        @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R12 cw_out", cw_out, 0);
        chk("R12 cw_valid", cw_valid, 0);
        chk("R12 cw_lost", cw_lost, 0);
        chk("R12 irq/active", {cw_irq, active}, 0);
    endtask

    task automatic t_single();
        int c0 = irq_cnt;
        len_sel = 2'b00; integ_en = 1'b0;
        idle(2);
        chk("R9 active before message", active, 0);
        send_n(6'h2A, 1);
        chk("R1 codeword order", cw_out, 6'h2A);
        chk("R2 valid set", cw_valid, 1);
        chk("R9 active after message", active, 1);
        chk("R11 one pulse", irq_cnt - c0, 1);
        send_n(6'h2A, 3);
        chk("R8 repeat loads once", irq_cnt - c0, 1);
        rd_reg();
        chk("R2 read clears valid", cw_valid, 0);
    endtask

    task automatic t_lost();
        send_n(6'h15, 1);
        chk("R5 new codeword loads", cw_out, 6'h15);
        send_n(6'h0C, 1);
        chk("R3 lost set", cw_lost, 1);
        chk("R3 newer codeword kept", cw_out, 6'h0C);
        rd_reg();
        chk("R2 read clears lost", cw_lost, 0);
        chk("R2 read clears valid", cw_valid, 0);
    endtask

    task automatic t_break();
        break_stream();
        chk("R7 break drops active", active, 0);
    endtask

    task automatic t_len10();
        int c0 = irq_cnt;
        len_sel = 2'b01;
        send_n(6'h33, 9);
        chk("R4 no load before 10", irq_cnt - c0, 0);
        send_n(6'h33, 1);
        chk("R4 load on 10th", irq_cnt - c0, 1);
        chk("R4 codeword", cw_out, 6'h33);
        rd_reg();
    endtask

    task automatic t_restart();
        int c0 = irq_cnt;
        send_n(6'h01, 5);
        send_n(6'h02, 9);
        chk("R5 count restarted", irq_cnt - c0, 0);
        send_n(6'h02, 1);
        chk("R5 load after restart", irq_cnt - c0, 1);
        chk("R5 codeword", cw_out, 6'h02);
        rd_reg();
    endtask

    task automatic t_break_count();
        int c0 = irq_cnt;
        send_n(6'h05, 6);
        break_stream();
        send_n(6'h05, 9);
        chk("R7 count restarted by break", irq_cnt - c0, 0);
        send_n(6'h05, 1);
        chk("R7 load after full run", irq_cnt - c0, 1);
        rd_reg();
    endtask

    task automatic t_len25();
        int c0 = irq_cnt;
        len_sel = 2'b10;
        break_stream();
        send_n(6'h3F, 24);
        chk("R4 no load before 25", irq_cnt - c0, 0);
        send_n(6'h3F, 1);
        chk("R4 load on 25th", irq_cnt - c0, 1);
        chk("R4 codeword all ones", cw_out, 6'h3F);
        rd_reg();
    endtask

    task automatic t_integ();
        int c0 = irq_cnt;
        len_sel = 2'b00; integ_en = 1'b1;
        break_stream();
        send_n(6'h11, 1);
        chk("R6 single message held", irq_cnt - c0, 0);
        chk("R9 active on first message", active, 1);
        send_n(6'h12, 1);
        chk("R6 mismatched pair held", irq_cnt - c0, 0);
        send_n(6'h12, 1);
        chk("R6 load on matching pair", irq_cnt - c0, 1);
        chk("R6 codeword", cw_out, 6'h12);
    endtask

    task automatic t_enable();
        int c0 = irq_cnt;
        enable = 1'b0;
        idle(2);
        chk("R10 active low when disabled", active, 0);
        send_n(6'h07, 2);
        chk("R10 no load when disabled", irq_cnt - c0, 0);
        chk("R10 codeword kept", cw_out, 6'h12);
        chk("R10 valid kept", cw_valid, 1);
        enable = 1'b1; integ_en = 1'b0;
        idle(2);
        send_n(6'h07, 1);
        chk("R10 receives after enable", cw_out, 6'h07);
        chk("R3 lost after enable", cw_lost, 1);
        rd_reg();
        chk("R11 pulse width", irq_wide, 0);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        enable = 1'b1;
        t_single();
        t_lost();
        t_break();
        t_len10();
        t_restart();
        t_break_count();
        t_len25();
        t_integ();
        t_enable();
        summary();
        $finish;
    end
endmodule